// File: doc/BRIEF.md
# UART Receive Queue with Trigger Threshold and Character Timeout

This block buffers bytes arriving from a serial receiver until the host reads them. It holds up to sixteen bytes in arrival order. It tells the host how many bytes are waiting and whether the fill level has reached a programmable threshold. It flags bytes lost to a full queue and line-break events. It also raises a pending timeout when data has sat untouched for four character times.

The block stores and decodes the FIFO control byte that the host writes. It uses that byte to clear the receive side, to emit a one-cycle flush request to a separate transmit queue, to switch queued operation on or off, and to pick the threshold. The character time is derived from a per-bit cycle count and the line format, so the timeout follows the configured baud rate and framing.

Top module: `uart_rx_queue`

## Requirements
- R1: The queue holds `DEPTH` (16) bytes. They are read back in arrival order, one byte per host read, on `rd_data` in the cycle after the read strobe. A read of an empty queue returns 0x00. `level` reports the stored count. After reset, `level`, every flag, `ctl_value` and `rd_data` are zero.
- R2: A byte that arrives while `level` equals `DEPTH` is dropped. The stored bytes and `level` stay unchanged, and `overrun` is set.
- R3: `trig_hit` is high when `data_rdy` is high and either queued mode is off (`ctl_value[0]` = 0), or `level` is at least the threshold selected by `ctl_value[7:6]`: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14.
- R4: In an accepted control write, bit 1 empties the receive queue, clears `data_rdy` and `brk_flag`, and cancels any pending timeout. Bit 2 produces a one-cycle `tx_flush` pulse after the write. If bit 0 differs from the stored bit 0, both actions happen whatever bits 1 and 2 hold.
- R5: An accepted control write stores the written value ANDed with 0xC9. A write equal to the stored value is ignored: no clear, no pulse, no change.
- R6: A received byte, a break, or a read that leaves bytes in the queue restarts a timer of four character times. If the timer runs out while the queue is not empty, `timeout_pend` is set in the cycle after the last timer cycle. Any host read clears it. Expiry with an empty queue sets nothing.
- R7: The character time is `bit_cycles` × (1 + 5 + `line_cfg[1:0]` + `line_cfg[3]` + (`line_cfg[2]` ? 2 : 1)) clock cycles. The timeout therefore fires exactly 4 × that many cycles after the restart edge.
- R8: A break event stores a 0x00 byte and sets both `brk_flag` and `data_rdy`.
- R9: Apart from the R4 clear, `data_rdy` and `brk_flag` fall only on a read that leaves `level` at zero.
- R10: A line-status read strobe clears `brk_flag` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DW | Received byte |
| brk_evt | input | 1 | Line break detected |
| rd_en | input | 1 | Host read of the receive data |
| lsr_rd | input | 1 | Host read of the line status |
| ctl_wr | input | 1 | FIFO control write strobe |
| ctl_wdata | input | 8 | FIFO control write value |
| bit_cycles | input | BIT_W | Clock cycles per serial bit |
| line_cfg | input | 4 | Framing: [1:0] data length − 5, [2] two stop bits, [3] parity present |
| rd_data | output | DW | Byte returned by the last read |
| level | output | $clog2(DEPTH+1) | Stored byte count |
| data_rdy | output | 1 | Receive data available |
| overrun | output | 1 | A byte was lost to a full queue |
| brk_flag | output | 1 | A break was received |
| timeout_pend | output | 1 | Character timeout pending |
| trig_hit | output | 1 | Fill threshold reached |
| ctl_value | output | 8 | Stored control value |
| tx_flush | output | 1 | One-cycle transmit-queue clear request |

## Verification
The bench builds the block with its default parameters: a depth of 16, byte-wide data and a 16-bit bit-time input. The full depth is therefore exercised, including the overrun at the seventeenth byte and the 14-byte threshold. The bit time is driven with very small values (2 and 3 cycles), so that a four-character timeout spans only 80 or 108 clock cycles. Both framing formulas can then be checked to the exact edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // bits of the FIFO control byte that are retained after a write
  localparam logic [7:0] CTL_KEEP = 8'hC9;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_FOUR = 2'b01,
    TRIG_EIGHT = 2'b10,
    TRIG_FOURTEEN = 2'b11
  } trig_sel_t;

  function automatic logic [4:0] trig_bytes(trig_sel_t sel);
    case (sel)
      TRIG_ONE:   return 5'd1;
      TRIG_FOUR:  return 5'd4;
      TRIG_EIGHT: return 5'd8;
      default:    return 5'd14;
    endcase
  endfunction

  // serial frame length in bit times: start + data + parity + stop
  function automatic logic [3:0] frame_bits(logic [3:0] cfg);
    return 4'd6 + {2'b00, cfg[1:0]} + {3'b000, cfg[3]} + (cfg[2] ? 4'd2 : 4'd1);
  endfunction

endpackage

// File: rtl/rxq_ctl_dec.sv
module rxq_ctl_dec
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] ctl_q,
  output logic       rx_clr,
  output logic       tx_flush
);

  logic accept;
  logic en_flip;

  assign accept  = wr && (wdata != ctl_q);
  assign en_flip = accept && (wdata[0] != ctl_q[0]);
  assign rx_clr  = accept && (wdata[1] || en_flip);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      tx_flush <= 1'b0;
    end else begin
      tx_flush <= accept && (wdata[2] || en_flip);
      if (accept) ctl_q <= wdata & CTL_KEEP;
    end
  end

  // R5: a write of the stored value changes nothing
  p_same_write_inert_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata == ctl_q) |=> ($stable(ctl_q) && !tx_flush));

  // R4: toggling the enable bit always requests a transmit flush
  p_enable_flip_flush_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[0] != ctl_q[0]) |=> tx_flush);

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] level,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head, tail;
  logic          push_ok, pop_ok;

  assign full    = (level == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (level != '0);

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage array kept reset-free so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[head] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (pop) begin
      rdata <= pop_ok ? mem[tail] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head  <= '0;
      tail  <= '0;
      level <= '0;
    end else begin
      if (push_ok) head <= nxt(head);
      if (pop_ok)  tail <= nxt(tail);
      level <= level + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R1: the count never exceeds the depth
  p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));

  // R2: a byte offered to a full queue leaves the count at the depth
  p_full_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (level == CW'(DEPTH)));

endmodule

// File: rtl/rxq_char_timer.sv
module rxq_char_timer
  import rxq_pkg::*;
#(
  parameter int BIT_W = 16,
  localparam int LIM_W = BIT_W + 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BIT_W-1:0] bit_cycles,
  input  logic [3:0]       line_cfg,
  input  logic             restart,
  input  logic             cancel,
  input  logic             ack,
  input  logic             nonempty,
  output logic             pend
);

  logic [LIM_W-1:0] lim_q;
  logic [LIM_W-1:0] cnt;
  logic             run;

  // four character times, registered to keep the multiplier off the timer path
  always_ff @(posedge clk) begin
    if (rst) lim_q <= '0;
    else     lim_q <= (LIM_W'(bit_cycles) * LIM_W'(frame_bits(line_cfg))) << 2;
  end

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      run  <= 1'b0;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (ack) pend <= 1'b0;
      if (restart) begin
        run <= 1'b1;
        cnt <= (lim_q == '0) ? '0 : lim_q - LIM_W'(1);
      end else if (run) begin
        if (cnt == '0) begin
          run <= 1'b0;
          if (nonempty && !ack) pend <= 1'b1;
        end else begin
          cnt <= cnt - LIM_W'(1);
        end
      end
    end
  end

  // R6: a timeout only appears while data is held
  p_pend_needs_data_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(nonempty));

  // R6: a host read removes the pending timeout
  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    ack |=> !pend);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int BIT_W = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_byte,
  input  logic             brk_evt,
  input  logic             rd_en,
  input  logic             lsr_rd,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  input  logic [BIT_W-1:0] bit_cycles,
  input  logic [3:0]       line_cfg,
  output logic [DW-1:0]    rd_data,
  output logic [CW-1:0]    level,
  output logic             data_rdy,
  output logic             overrun,
  output logic             brk_flag,
  output logic             timeout_pend,
  output logic             trig_hit,
  output logic [7:0]       ctl_value,
  output logic             tx_flush
);

  logic          rx_clr;
  logic          push;
  logic [DW-1:0] push_data;
  logic          full;
  logic          leaves_empty;
  logic          restart;

  assign push         = rx_valid || brk_evt;
  assign push_data    = brk_evt ? '0 : rx_byte;
  assign leaves_empty = rd_en && (level <= CW'(1)) && !push;
  assign restart      = push || (rd_en && level > CW'(1));

  rxq_ctl_dec u_ctl (
    .clk      (clk),
    .rst      (rst),
    .wr       (ctl_wr),
    .wdata    (ctl_wdata),
    .ctl_q    (ctl_value),
    .rx_clr   (rx_clr),
    .tx_flush (tx_flush)
  );

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .clr   (rx_clr),
    .push  (push),
    .pop   (rd_en),
    .wdata (push_data),
    .rdata (rd_data),
    .level (level),
    .full  (full)
  );

  rxq_char_timer #(.BIT_W(BIT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .bit_cycles (bit_cycles),
    .line_cfg   (line_cfg),
    .restart    (restart),
    .cancel     (rx_clr),
    .ack        (rd_en),
    .nonempty   (level != '0),
    .pend       (timeout_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_rdy <= 1'b0;
      brk_flag <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (push && full)  overrun <= 1'b1;
      else if (lsr_rd)   overrun <= 1'b0;

      if (rx_clr) begin
        data_rdy <= 1'b0;
        brk_flag <= 1'b0;
      end else begin
        if (push)              data_rdy <= 1'b1;
        else if (leaves_empty) data_rdy <= 1'b0;

        if (brk_evt)                           brk_flag <= 1'b1;
        else if (lsr_rd || leaves_empty)       brk_flag <= 1'b0;
      end
    end
  end

  assign trig_hit = data_rdy &&
                    (!ctl_value[0] || level >= CW'(trig_bytes(trig_sel_t'(ctl_value[7:6]))));

  // R2: a byte offered to a full queue raises the overrun flag
  p_overrun_on_full_r2: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> overrun);

  // R8: a break marks both break and data-ready
  p_break_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (brk_evt && !rx_clr) |=> (brk_flag && data_rdy && level != '0));

  // R10: a line-status read drops break and overrun when nothing new arrives
  p_lsr_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !rx_valid && !brk_evt) |=> (!overrun && !brk_flag));

  // R9: data-ready persists until a read or a receive clear
  p_dr_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (data_rdy && !rd_en && !rx_clr) |=> data_rdy);

endmodule

// File: tb/test_uart_rx_queue.sv
`timescale 1ns/1ps
module test_uart_rx_queue;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        brk_evt = 1'b0;
  logic        rd_en = 1'b0;
  logic        lsr_rd = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [15:0] bit_cycles = 16'd2;
  logic [3:0]  line_cfg = 4'b0011;
  logic [7:0]  rd_data;
  logic [4:0]  level;
  logic        data_rdy, overrun, brk_flag, timeout_pend, trig_hit, tx_flush;
  logic [7:0]  ctl_value;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  logic rd_seen = 1'b0;

  always #4 clk = ~clk;

  uart_rx_queue i_uart_rx_queue (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .brk_evt(brk_evt),
    .rd_en(rd_en), .lsr_rd(lsr_rd), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .bit_cycles(bit_cycles), .line_cfg(line_cfg), .rd_data(rd_data), .level(level),
    .data_rdy(data_rdy), .overrun(overrun), .brk_flag(brk_flag),
    .timeout_pend(timeout_pend), .trig_hit(trig_hit), .ctl_value(ctl_value),
    .tx_flush(tx_flush)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // driver tasks: every accepted byte is pushed to the scoreboard
  task automatic send(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1;
    tick();
    rx_valid = 1'b0;
    if (exp_q.size() < 16) exp_q.push_back(b);
  endtask

  task automatic send_break();
    brk_evt = 1'b1;
    tick();
    brk_evt = 1'b0;
    if (exp_q.size() < 16) exp_q.push_back(8'h00);
  endtask

  task automatic host_read();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic status_read();
    lsr_rd = 1'b1;
    tick();
    lsr_rd = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v, input bit clears);
    ctl_wr = 1'b1; ctl_wdata = v;
    tick();
    ctl_wr = 1'b0;
    if (clears) exp_q.delete();
  endtask

  // monitor: compare every read result against the scoreboard
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
      check("R1", "read data in order", {24'd0, rd_data}, {24'd0, e});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check("R1", "reset level", level, 0);
    check("R1", "reset flags", {data_rdy, overrun, brk_flag, timeout_pend, trig_hit, tx_flush}, 0);
    check("R1", "reset ctl", ctl_value, 0);
    check("R1", "reset rd_data", rd_data, 0);

    // enable queued mode: enable change forces both clears
    wr_ctl(8'h01, 1);
    check("R4", "flush pulse on enable", tx_flush, 1);
    check("R5", "stored ctl", ctl_value, 8'h01);
    tick();
    check("R4", "flush pulse one cycle", tx_flush, 0);

    send(8'hA1); send(8'hB2); send(8'hC3);
    check("R1", "level after 3", level, 3);
    check("R9", "data ready", data_rdy, 1);
    check("R3", "trigger at 1", trig_hit, 1);
    host_read();
    check("R9", "data ready held", data_rdy, 1);
    host_read(); host_read();
    check("R9", "data ready cleared at empty", data_rdy, 0);
    check("R1", "level empty", level, 0);
    host_read();  // empty read returns 0 (R1, via scoreboard)

    // trigger thresholds
    wr_ctl(8'h41, 0);
    check("R5", "stored 0x41", ctl_value, 8'h41);
    check("R4", "no flush without bit 2", tx_flush, 0);
    send(8'h01); send(8'h02); send(8'h03);
    check("R3", "below threshold 4", trig_hit, 0);
    send(8'h04);
    check("R3", "at threshold 4", trig_hit, 1);
    wr_ctl(8'h81, 0);
    check("R3", "below threshold 8", trig_hit, 0);
    send(8'h05); send(8'h06); send(8'h07); send(8'h08);
    check("R3", "at threshold 8", trig_hit, 1);
    wr_ctl(8'hC1, 0);
    check("R3", "below threshold 14", trig_hit, 0);
    wr_ctl(8'hC3, 1);
    check("R4", "rx clear level", level, 0);
    check("R4", "rx clear data ready", data_rdy, 0);
    check("R5", "bit 1 not kept", ctl_value, 8'hC1);

    // same-value write is ignored; bit 2 alone flushes tx only
    send(8'h11); send(8'h22);
    wr_ctl(8'hC1, 0);
    check("R5", "same write keeps level", level, 2);
    check("R5", "same write no pulse", tx_flush, 0);
    wr_ctl(8'hC5, 0);
    check("R4", "bit 2 flush pulse", tx_flush, 1);
    check("R4", "bit 2 keeps rx", level, 2);
    host_read(); host_read();

    // overrun
    for (int i = 0; i < 16; i++) send(8'h30 + 8'(i));
    check("R2", "full level", level, 16);
    check("R2", "no overrun yet", overrun, 0);
    check("R3", "threshold 14 reached", trig_hit, 1);
    send(8'hEE);
    check("R2", "overrun set", overrun, 1);
    check("R2", "level unchanged", level, 16);
    for (int i = 0; i < 16; i++) host_read();
    check("R10", "overrun held until status read", overrun, 1);
    status_read();
    check("R10", "overrun cleared", overrun, 0);

    // break handling
    send_break();
    check("R8", "break level", level, 1);
    check("R8", "break flag", brk_flag, 1);
    check("R8", "break data ready", data_rdy, 1);
    send(8'h5A);
    host_read();
    check("R9", "break held while data left", brk_flag, 1);
    status_read();
    check("R10", "status read clears break", brk_flag, 0);
    check("R9", "data ready kept", data_rdy, 1);
    host_read();
    check("R9", "data ready clears at empty", data_rdy, 0);
    send_break();
    host_read();
    check("R9", "break clears at empty", brk_flag, 0);

    // timeout: 2 cycles/bit, 10-bit frame -> 80 cycles
    send(8'h77);
    repeat (79) tick();
    check("R7", "no timeout before 80", timeout_pend, 0);
    tick();
    check("R6", "timeout at 80", timeout_pend, 1);
    host_read();
    check("R6", "read clears timeout", timeout_pend, 0);
    repeat (100) tick();
    check("R6", "empty queue no timeout", timeout_pend, 0);

    // 3 cycles/bit, 5 data + parity + 2 stop -> 9 bits, 108 cycles
    bit_cycles = 16'd3; line_cfg = 4'b1100;
    tick(); tick();
    send(8'h66);
    repeat (107) tick();
    check("R7", "no timeout before 108", timeout_pend, 0);
    tick();
    check("R7", "timeout at 108", timeout_pend, 1);
    send(8'h67);
    host_read();
    check("R6", "read restarts and clears", timeout_pend, 0);
    repeat (107) tick();
    check("R6", "restarted timer not expired", timeout_pend, 0);
    tick();
    check("R6", "restarted timer expired", timeout_pend, 1);
    host_read();

    // disable: enable change clears, threshold becomes 1
    send(8'h01); send(8'h02);
    wr_ctl(8'hC0, 1);
    check("R4", "disable forces rx clear", level, 0);
    check("R4", "disable forces flush", tx_flush, 1);
    send(8'h03);
    check("R3", "disabled threshold 1", trig_hit, 1);
    host_read();
    tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule